// File: doc/BRIEF.md
# Lockable Drive-Timing Configuration Window

This block sits on the eight-byte command-block address range of a disk controller. In its normal state, called IDE mode, every host access passes straight through to the task-file registers: the address, the data and the strobes are forwarded in the same cycle, and read data comes back from the task file.

A fixed sequence of host accesses opens configuration mode. The sequence is two consecutive 16-bit reads at offset 1, followed by an 8-bit write of 0x03 to offset 2. In configuration mode the task file is hidden, and the same offsets reach a small register bank instead. The bank holds a read-cycle timing word and a write-cycle timing word for each of two drives, reached through a drive-select bit. It also holds a control register, a read-only strap byte and a miscellaneous register, which carries the drive select and a shared address-setup field.

Timing words are first written into staging registers. The active timing outputs, which downstream bus-timing logic consumes, change only when the commit command is written. A relock write to offset 2 returns the window to IDE mode.

Top module: `ata_cfg_window`

## Requirements
- R1: After synchronous reset the window is in IDE mode (`cfg_mode`=0) and the unlock tracker is idle. Every active timing output holds DEF_TIMING (default 0xFF), `act_setup` is all ones (0xF), and the staging words hold DEF_TIMING.
- R2: In IDE mode, `tf_rd`, `tf_wr`, `tf_addr`, `tf_wide` and `tf_wdata` follow the host inputs in the same cycle, and `host_rdata` equals `tf_rdata`.
- R3: Two 16-bit reads (`host_wide`=1) at offset 1, then an 8-bit write (`host_wide`=0) of 0x03 to offset 2, set `cfg_mode` from the next cycle. Cycles with no access between these steps do not break the sequence. The unlocking write itself still reaches the task file.
- R4: Any other access before the sequence completes returns the tracker to idle. This covers a different offset, a narrow read, a write with the wrong value or the wrong width, and a write after fewer than two reads. The breaking access is passed through normally.
- R5: While `cfg_mode`=1, `tf_rd` and `tf_wr` stay 0, and `host_rdata` comes from the register bank.
- R6: Configuration offsets are mapped as follows. Offset 0 is the read timing word and offset 1 the write timing word, each for the drive chosen by miscellaneous bit 0. Offset 3 is the control register. Offset 5 is the strap byte, equal to parameter STRAP (default 0x01), read-only. Offset 6 is the miscellaneous register. All of them read back the last value written.
- R7: Writing 0x85 to offset 3 in configuration mode copies, by the next cycle, each drive's staging words to `act_rd_tim`/`act_wr_tim` (drive n in bits [8n+7:8n]). It also copies miscellaneous bits [7:4] to `act_setup`. A control write of any other value leaves the active outputs unchanged.
- R8: Writes to the timing or miscellaneous registers without a commit leave every active output unchanged.
- R9: Writing 0x83 to offset 2 in configuration mode clears `cfg_mode` from the next cycle. Any other value written at offset 2 leaves the window in configuration mode.
- R10: In configuration mode, offsets 2, 4 and 7 read as 0x00, and writes to offsets 4 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Host access offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| tf_addr | output | 3 | Forwarded offset to task file |
| tf_rd | output | 1 | Forwarded read strobe |
| tf_wr | output | 1 | Forwarded write strobe |
| tf_wide | output | 1 | Forwarded access width |
| tf_wdata | output | 8 | Forwarded write data |
| tf_rdata | input | 8 | Task-file read data |
| cfg_mode | output | 1 | 1 = configuration mode |
| act_rd_tim | output | 16 | Active read timing words, drive 1 high byte |
| act_wr_tim | output | 16 | Active write timing words, drive 1 high byte |
| act_setup | output | 4 | Active shared address-setup field |

## Verification
Pass-through strobes, forwarded fields and read data are combinational, so they are due in the same cycle as the host access. Mode changes, staging writes and commits become visible one cycle after the access that causes them. The bench drives each access just after a falling edge and compares the combinational results a moment later. It advances a behavioural model at the rising edge and compares every registered output at the next falling edge. A one-cycle slip in any result therefore shows up as a mismatch on that very cycle.

// File: rtl/ata_cfg_pkg.sv
// Shared constants and types for the lockable drive-timing window.
// Assumes a 3-bit command-block offset and 8-bit register data.
package ata_cfg_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_t;

    // offsets used by the unlock sequence
    localparam int UNLOCK_RD_OFS = 1;
    localparam int KEY_OFS       = 2;

    // configuration-mode register offsets
    localparam int OFS_RDTIM = 0;
    localparam int OFS_WRTIM = 1;
    localparam int OFS_CTRL  = 3;
    localparam int OFS_STRAP = 5;
    localparam int OFS_MISC  = 6;

    localparam logic [7:0] KEY_UNLOCK = 8'h03;
    localparam logic [7:0] KEY_RELOCK = 8'h83;
    localparam logic [7:0] CMD_COMMIT = 8'h85;
endpackage

// File: rtl/ata_unlock_seq.sv
// Tracks the host access sequence that opens configuration mode and the
// relock write that closes it. Assumes host_rd and host_wr are single-cycle
// strobes, never both high in one cycle.
module ata_unlock_seq
    import ata_cfg_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          wide,
    input  logic [DW-1:0] wdata,
    output logic          cfg_mode
);
    seq_t st;
    logic rd_step, key_hit, relock_hit;

    // decode of the sequence steps and the relock write
    always_comb begin
        rd_step    = rd && wide && (addr == AW'(UNLOCK_RD_OFS));
        key_hit    = wr && !wide && (addr == AW'(KEY_OFS)) &&
                     (wdata == DW'(KEY_UNLOCK)) && (st == SEQ_TWO);
        relock_hit = wr && (addr == AW'(KEY_OFS)) && (wdata == DW'(KEY_RELOCK));
    end

    // sequence tracker and mode flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            cfg_mode <= 1'b0;
        end else if (!cfg_mode) begin
            if (rd_step)
                st <= (st == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
            else if (key_hit) begin
                st       <= SEQ_IDLE;
                cfg_mode <= 1'b1;
            end else if (rd || wr)
                st <= SEQ_IDLE;
        end else begin
            st <= SEQ_IDLE;
            if (relock_hit)
                cfg_mode <= 1'b0;
        end
    end

    p_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && key_hit) |=> cfg_mode);
    p_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && wr && addr != AW'(KEY_OFS)) |=> (!cfg_mode && st == SEQ_IDLE));
    p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && relock_hit) |=> !cfg_mode);
    p_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && !relock_hit) |=> cfg_mode);
endmodule

// File: rtl/ata_timing_bank.sv
// Configuration register bank: per-drive staging and active timing words,
// control, strap and miscellaneous registers, and the commit transfer.
// Assumes NDEV is a power of two, so the drive select indexes every drive.
module ata_timing_bank
    import ata_cfg_pkg::*;
#(
    parameter int          AW         = 3,
    parameter int          DW         = 8,
    parameter int          NDEV       = 2,
    parameter int          SETUP_LSB  = 4,
    parameter logic [DW-1:0] DEF_TIMING = 8'hFF,
    parameter logic [DW-1:0] STRAP      = 8'h01
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_mode,
    input  logic [AW-1:0]            addr,
    input  logic                     wr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic [NDEV-1:0][DW-1:0]  act_rd,
    output logic [NDEV-1:0][DW-1:0]  act_wr,
    output logic [DW-SETUP_LSB-1:0]  act_setup
);
    localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam int SW   = DW - SETUP_LSB;

    logic [NDEV-1:0][DW-1:0] stg_rd, stg_wr;
    logic [DW-1:0]           misc_q, ctrl_q;
    logic [SELW-1:0]         sel;
    logic                    we, commit;

    // write enable, drive select and commit decode
    always_comb begin
        we     = cfg_mode && wr;
        sel    = misc_q[SELW-1:0];
        commit = we && (addr == AW'(OFS_CTRL)) && (wdata == CMD_COMMIT);
    end

    // control and miscellaneous registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc_q <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            if (addr == AW'(OFS_MISC)) misc_q <= wdata;
            if (addr == AW'(OFS_CTRL)) ctrl_q <= wdata;
        end
    end

    // shared address-setup field, taken on commit
    always_ff @(posedge clk) begin
        if (!rst_n)      act_setup <= '1;
        else if (commit) act_setup <= misc_q[DW-1:SETUP_LSB];
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        // staging words for drive d, written through the drive select
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_rd[d] <= DEF_TIMING;
                stg_wr[d] <= DEF_TIMING;
            end else if (we && sel == SELW'(d)) begin
                if (addr == AW'(OFS_RDTIM)) stg_rd[d] <= wdata;
                if (addr == AW'(OFS_WRTIM)) stg_wr[d] <= wdata;
            end
        end

        // active words for drive d, loaded only on commit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_rd[d] <= DEF_TIMING;
                act_wr[d] <= DEF_TIMING;
            end else if (commit) begin
                act_rd[d] <= stg_rd[d];
                act_wr[d] <= stg_wr[d];
            end
        end

        p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            commit |=> (act_rd[d] == $past(stg_rd[d]) && act_wr[d] == $past(stg_wr[d])));
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> ($stable(act_rd[d]) && $stable(act_wr[d])));
    end

    // register read-back multiplexer
    always_comb begin
        case (addr)
            AW'(OFS_RDTIM): rdata = stg_rd[sel];
            AW'(OFS_WRTIM): rdata = stg_wr[sel];
            AW'(OFS_CTRL):  rdata = ctrl_q;
            AW'(OFS_STRAP): rdata = STRAP;
            AW'(OFS_MISC):  rdata = misc_q;
            default:        rdata = '0;
        endcase
    end

    p_setup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_setup));
    p_setup_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> act_setup == $past(misc_q[DW-1:DW-SW]));
endmodule

// File: rtl/ata_cfg_window.sv
// Top of the lockable drive-timing window. Passes host accesses to the task
// file in IDE mode and steers them to the timing bank in configuration mode.
// Assumes a single host master with one-cycle read and write strobes.
module ata_cfg_window #(
    parameter int          AW         = 3,
    parameter int          DW         = 8,
    parameter int          NDEV       = 2,
    parameter int          SETUP_LSB  = 4,
    parameter logic [7:0]  DEF_TIMING = 8'hFF,
    parameter logic [7:0]  STRAP      = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          host_addr,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic                   host_wide,
    input  logic [DW-1:0]          host_wdata,
    output logic [DW-1:0]          host_rdata,
    output logic [AW-1:0]          tf_addr,
    output logic                   tf_rd,
    output logic                   tf_wr,
    output logic                   tf_wide,
    output logic [DW-1:0]          tf_wdata,
    input  logic [DW-1:0]          tf_rdata,
    output logic                   cfg_mode,
    output logic [NDEV*DW-1:0]     act_rd_tim,
    output logic [NDEV*DW-1:0]     act_wr_tim,
    output logic [DW-SETUP_LSB-1:0] act_setup
);
    logic [DW-1:0]           bank_rdata;
    logic [NDEV-1:0][DW-1:0] act_rd, act_wr;

    ata_unlock_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr(host_addr), .rd(host_rd),
        .wr(host_wr), .wide(host_wide), .wdata(host_wdata), .cfg_mode(cfg_mode)
    );

    ata_timing_bank #(
        .AW(AW), .DW(DW), .NDEV(NDEV), .SETUP_LSB(SETUP_LSB),
        .DEF_TIMING(DW'(DEF_TIMING)), .STRAP(DW'(STRAP))
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .addr(host_addr),
        .wr(host_wr), .wdata(host_wdata), .rdata(bank_rdata),
        .act_rd(act_rd), .act_wr(act_wr), .act_setup(act_setup)
    );

    // pass-through toward the task file and read-data steering
    always_comb begin
        tf_addr    = host_addr;
        tf_wide    = host_wide;
        tf_wdata   = host_wdata;
        tf_rd      = host_rd && !cfg_mode;
        tf_wr      = host_wr && !cfg_mode;
        host_rdata = cfg_mode ? bank_rdata : tf_rdata;
        act_rd_tim = act_rd;
        act_wr_tim = act_wr;
    end

    p_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> (!tf_rd && !tf_wr));
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> (tf_rd == host_rd && tf_wr == host_wr));
endmodule

// File: tb/ata_cfg_window_test.sv
// Bench for the lockable drive-timing window: behavioural model compared
// on every clock.
module ata_cfg_window_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] host_addr;
    logic       host_rd, host_wr, host_wide;
    logic [7:0] host_wdata, host_rdata;
    logic [2:0] tf_addr;
    logic       tf_rd, tf_wr, tf_wide;
    logic [7:0] tf_wdata, tf_rdata;
    logic       cfg_mode;
    logic [15:0] act_rd_tim, act_wr_tim;
    logic [3:0] act_setup;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    int m_mode, m_cnt, m_misc, m_ctrl, m_setup;
    int m_srd[2], m_swr[2], m_ard[2], m_awr[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    // task-file side: returns a pattern derived from the offset
    assign tf_rdata = 8'hA0 ^ {5'd0, tf_addr};

    ata_cfg_window uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wide(host_wide), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .tf_addr(tf_addr), .tf_rd(tf_rd), .tf_wr(tf_wr),
        .tf_wide(tf_wide), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .cfg_mode(cfg_mode), .act_rd_tim(act_rd_tim), .act_wr_tim(act_wr_tim),
        .act_setup(act_setup)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int a);
        if (m_mode == 0) return 'hA0 ^ a;
        case (a)
            0: return m_srd[m_misc & 1];
            1: return m_swr[m_misc & 1];
            3: return m_ctrl;
            5: return 'h01;
            6: return m_misc;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 0; m_cnt = 0; m_misc = 0; m_ctrl = 0; m_setup = 'hF;
        for (int d = 0; d < 2; d++) begin
            m_srd[d] = 'hFF; m_swr[d] = 'hFF; m_ard[d] = 'hFF; m_awr[d] = 'hFF;
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, "cfg_mode", cfg_mode, m_mode);
        chk(tag, "act_rd0", act_rd_tim[7:0], m_ard[0]);
        chk(tag, "act_rd1", act_rd_tim[15:8], m_ard[1]);
        chk(tag, "act_wr0", act_wr_tim[7:0], m_awr[0]);
        chk(tag, "act_wr1", act_wr_tim[15:8], m_awr[1]);
        chk(tag, "act_setup", act_setup, m_setup);
    endtask

    // one host cycle: drive, check, advance the model at the rising edge
    task automatic acc(input string tag, input bit rd, input bit wr, input bit wide,
                       input int a, input int d);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_wide = wide;
        host_addr = 3'(a); host_wdata = 8'(d);
        #1;
        check_regs(tag);
        chk(tag, "tf_rd", tf_rd, (m_mode == 0) ? int'(rd) : 0);
        chk(tag, "tf_wr", tf_wr, (m_mode == 0) ? int'(wr) : 0);
        if (m_mode == 0) begin
            chk(tag, "tf_addr", tf_addr, a);
            chk(tag, "tf_wide", tf_wide, wide);
            chk(tag, "tf_wdata", tf_wdata, d);
        end
        if (rd) chk(tag, "host_rdata", host_rdata, exp_rdata(a));
        @(posedge clk);
        if (m_mode == 0) begin
            if (rd && wide && a == 1) m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
            else if (wr && !wide && a == 2 && d == 'h03 && m_cnt == 2) begin
                m_mode = 1; m_cnt = 0;
            end else if (rd || wr) m_cnt = 0;
        end else if (wr) begin
            case (a)
                0: m_srd[m_misc & 1] = d;
                1: m_swr[m_misc & 1] = d;
                2: if (d == 'h83) m_mode = 0;
                3: begin
                    m_ctrl = d;
                    if (d == 'h85) begin
                        for (int k = 0; k < 2; k++) begin
                            m_ard[k] = m_srd[k]; m_awr[k] = m_swr[k];
                        end
                        m_setup = (m_misc >> 4) & 'hF;
                    end
                end
                6: m_misc = d;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input string tag);
        acc(tag, 0, 0, 0, 0, 0);
    endtask

    task automatic do_unlock(input string tag);
        acc(tag, 1, 0, 1, 1, 0);
        acc(tag, 1, 0, 1, 1, 0);
        acc(tag, 0, 1, 0, 2, 'h03);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_rd = 0; host_wr = 0; host_wide = 0;
        host_addr = 0; host_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        idle("R1");
        idle("R1");
        // R2: pass-through in IDE mode
        acc("R2", 1, 0, 0, 7, 0);
        acc("R2", 0, 1, 1, 3, 'h5A);
        acc("R2", 1, 0, 1, 0, 0);
        // R4: broken sequences
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 1, 0, 0, 1, 0);
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 0, 1, 0, 2, 'h03);
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 1, 0, 1, 1, 0); acc("R4", 0, 1, 0, 2, 'h04);
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 1, 0, 1, 1, 0); acc("R4", 0, 1, 1, 2, 'h03);
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 1, 0, 1, 1, 0); acc("R4", 1, 0, 1, 2, 0);
        acc("R4", 0, 1, 0, 2, 'h03);
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 0, 1, 0, 4, 'h11);
        acc("R4", 1, 0, 1, 1, 0); acc("R4", 0, 1, 0, 2, 'h03);
        idle("R4");
        // R3: unlock with an idle gap inside the sequence
        acc("R3", 1, 0, 1, 1, 0); idle("R3");
        acc("R3", 1, 0, 1, 1, 0); idle("R3");
        acc("R3", 0, 1, 0, 2, 'h03);
        idle("R3");
        // R5: task file hidden
        acc("R5", 1, 0, 0, 7, 0);
        acc("R5", 0, 1, 0, 7, 'h66);
        // R6 and R8: program both drives through the select bit
        acc("R6", 0, 1, 0, 6, 'h20);
        acc("R6", 0, 1, 0, 0, 'h59);
        acc("R6", 0, 1, 0, 1, 'h46);
        acc("R6", 0, 1, 0, 6, 'h21);
        acc("R6", 0, 1, 0, 0, 'h33);
        acc("R6", 0, 1, 0, 1, 'h22);
        acc("R6", 1, 0, 0, 0, 0); acc("R6", 1, 0, 0, 1, 0);
        acc("R6", 1, 0, 0, 6, 0); acc("R6", 1, 0, 0, 5, 0);
        acc("R6", 0, 1, 0, 5, 'h77); acc("R6", 1, 0, 0, 5, 0);
        acc("R6", 0, 1, 0, 6, 'h20);
        acc("R6", 1, 0, 0, 0, 0); acc("R6", 1, 0, 0, 1, 0);
        acc("R8", 0, 1, 0, 6, 'h31);
        idle("R8");
        // R7: non-commit control value, then commit
        acc("R7", 0, 1, 0, 3, 'h11);
        acc("R7", 1, 0, 0, 3, 0);
        acc("R7", 0, 1, 0, 3, 'h85);
        idle("R7");
        acc("R7", 1, 0, 0, 3, 0);
        // R10: undefined offsets
        acc("R10", 0, 1, 0, 4, 'h5A);
        acc("R10", 0, 1, 0, 7, 'hA5);
        acc("R10", 1, 0, 0, 4, 0); acc("R10", 1, 0, 0, 7, 0);
        acc("R10", 1, 0, 0, 2, 0);
        acc("R10", 1, 0, 0, 0, 0); acc("R10", 1, 0, 0, 6, 0);
        // R9: other value at offset 2 keeps the mode, relock leaves it
        acc("R9", 0, 1, 0, 2, 'h03);
        idle("R9");
        acc("R9", 0, 1, 0, 2, 'h83);
        idle("R9");
        acc("R9", 1, 0, 0, 0, 0);
        acc("R9", 0, 1, 0, 6, 'h44);
        // R8: staging change then second unlock shows actives kept
        do_unlock("R8");
        acc("R8", 0, 1, 0, 0, 'h10);
        acc("R8", 1, 0, 0, 6, 0);
        acc("R7", 0, 1, 0, 3, 'h85);
        idle("R7");
        acc("R9", 0, 1, 0, 2, 'h83);
        idle("R9");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule